// File: doc/BRIEF.md
# Per-Port Memory Address Generator

This block produces the address for each access on one port of a synchronous memory. A register of `ADDR_W` bits, 14 by default, changes on every rising clock edge. Three active-low controls, sampled at that edge, decide its next value. A clear forces zero. A load takes the address from the external bus. An increment steps the address by one. With none of these asserted, the address is held.

The registered value, `acc_addr`, is the address that the current access uses. After a load it equals the external bus, and otherwise it is the running count. A clear costs no cycle: the access in the cycle after the clear edge targets address zero, and the next edge may already load or step the address.

Chip-select and byte-lane inputs reach the block so that it can sit beside the rest of the port logic. They have no effect on the address. An asynchronous power-on reset also clears the register.

Top module: `port_addr_gen`

## Requirements
- R1: While `por_n` is low, `acc_addr` is 0 at once, without waiting for a clock edge.
- R2: At a rising edge where `ctr_clr_n` is low, `acc_addr` becomes 0, whatever the values of `ld_n`, `inc_n` and `ext_addr`.
- R3: At a rising edge where `ctr_clr_n` is high and `ld_n` is low, `acc_addr` becomes `ext_addr`, even if `inc_n` is low.
- R4: At a rising edge where `ctr_clr_n` and `ld_n` are high and `inc_n` is low, `acc_addr` becomes its previous value plus one.
- R5: At a rising edge where all three controls are high, `acc_addr` keeps its value and `ext_addr` is ignored.
- R6: Incrementing from the largest address (all ones, 16383 for 14 bits) gives 0.
- R7: `bank_sel_n`, `bank_sel` and `lane_en_n` have no effect: clears, loads, increments and holds give the same `acc_addr` whether the port is selected or not.
- R8: The edge right after a clear may load or increment with no idle cycle, so a clear followed by an increment gives address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ctr_clr_n | input | 1 | Synchronous clear to address 0, active low, highest priority |
| ld_n | input | 1 | Load from the external bus, active low |
| inc_n | input | 1 | Step the address by one, active low |
| ext_addr | input | ADDR_W | External address bus |
| bank_sel_n | input | 1 | Active-low chip select, has no effect on the address |
| bank_sel | input | 1 | Active-high chip select, has no effect on the address |
| lane_en_n | input | LANES | Active-low byte-lane enables, have no effect on the address |
| acc_addr | output | ADDR_W | Address used by the current access |

## Verification
The bound checker tests the priority order on every clock cycle: clear to zero, load from the bus, step by one with wrap, and hold. It also checks that the address is zero throughout power-on reset. That chip selects and byte lanes leave the address alone cannot be stated as one property, so the bench shows it by repeating the same control sequence with the port deselected. The zero-cost clear and the wrap from the largest address are likewise driven by directed scenarios. A reference model then follows long random mixes of the three controls.

// File: rtl/pag_pkg.sv
package pag_pkg;

   // Decoded action for one clock edge, listed from lowest to highest priority.
   typedef enum logic [1:0] {
      PAG_HOLD  = 2'd0,
      PAG_INC   = 2'd1,
      PAG_LOAD  = 2'd2,
      PAG_CLEAR = 2'd3
   } pag_op_e;

   localparam int unsigned PAG_MIN_W = 2;
   localparam int unsigned PAG_MAX_W = 32;

endpackage

// File: rtl/pag_ctl.sv
module pag_ctl
   import pag_pkg::*;
(
   input  logic    clr_n,
   input  logic    ld_n,
   input  logic    inc_n,
   output pag_op_e op
);

   // Fixed priority: clear, then load, then increment, then hold.
   always_comb begin
      if (!clr_n)
         op = PAG_CLEAR;
      else if (!ld_n)
         op = PAG_LOAD;
      else if (!inc_n)
         op = PAG_INC;
      else
         op = PAG_HOLD;
   end

endmodule

// File: rtl/pag_incr.sv
module pag_incr #(
   parameter int unsigned W = 14
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] sum
);

   logic [W:0] carry;

   assign carry[0] = 1'b1;

   // Add one with a carry chain of half adders; the carry out of the top bit
   // is dropped, so the largest value wraps to zero.
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign sum[b]     = a[b] ^ carry[b];
      assign carry[b+1] = a[b] & carry[b];
   end

   logic unused_carry_out;
   assign unused_carry_out = carry[W];

endmodule

// File: rtl/pag_reg.sv
module pag_reg
   import pag_pkg::*;
#(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         por_n,
   input  pag_op_e      op,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] inc_val,
   output logic [W-1:0] q
);

   logic [W-1:0] d;

   always_comb begin
      unique case (op)
         PAG_CLEAR: d = '0;
         PAG_LOAD:  d = load_val;
         PAG_INC:   d = inc_val;
         default:   d = q;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         q <= '0;
      else
         q <= d;
   end

endmodule

// File: rtl/port_addr_gen.sv
module port_addr_gen
   import pag_pkg::*;
#(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ctr_clr_n,
   input  logic              ld_n,
   input  logic              inc_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              bank_sel_n,
   input  logic              bank_sel,
   input  logic [LANES-1:0]  lane_en_n,
   output logic [ADDR_W-1:0] acc_addr
);

   if (ADDR_W < PAG_MIN_W || ADDR_W > PAG_MAX_W) begin : g_bad_width
      $error("port_addr_gen: ADDR_W out of supported range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("port_addr_gen: LANES must be at least 1");
   end

   pag_op_e           op;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_plus;

   pag_ctl u_ctl (
      .clr_n (ctr_clr_n),
      .ld_n  (ld_n),
      .inc_n (inc_n),
      .op    (op)
   );

   pag_incr #(.W(ADDR_W)) u_incr (
      .a   (addr_q),
      .sum (addr_plus)
   );

   pag_reg #(.W(ADDR_W)) u_reg (
      .clk      (clk),
      .por_n    (por_n),
      .op       (op),
      .load_val (ext_addr),
      .inc_val  (addr_plus),
      .q        (addr_q)
   );

   assign acc_addr = addr_q;

   // Select and lane inputs are accepted but deliberately kept out of the address path.
   logic unused_sel;
   assign unused_sel = ^{bank_sel_n, bank_sel, lane_en_n};

endmodule

// File: rtl/pag_chk.sv
module pag_chk #(
   parameter int unsigned ADDR_W = 14
) (
   input logic              clk,
   input logic              por_n,
   input logic              ctr_clr_n,
   input logic              ld_n,
   input logic              inc_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [ADDR_W-1:0] acc_addr
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   // R1: zero while power-on reset is held
   always @(negedge clk) begin
      if (por_n == 1'b0)
         a_r1_por_zero: assert (acc_addr == '0);
   end

   a_r2_clear: assert property (@(posedge clk) disable iff (!por_n)
      !ctr_clr_n |=> acc_addr == '0);

   a_r3_load: assert property (@(posedge clk) disable iff (!por_n)
      (ctr_clr_n && !ld_n) |=> acc_addr == $past(ext_addr));

   a_r4_incr: assert property (@(posedge clk) disable iff (!por_n)
      (ctr_clr_n && ld_n && !inc_n) |=> acc_addr == $past(acc_addr) + ONE);

   a_r5_hold: assert property (@(posedge clk) disable iff (!por_n)
      (ctr_clr_n && ld_n && inc_n) |=> $stable(acc_addr));

   a_r6_wrap: assert property (@(posedge clk) disable iff (!por_n)
      (ctr_clr_n && ld_n && !inc_n && acc_addr == '1) |=> acc_addr == '0);

endmodule

bind port_addr_gen pag_chk #(.ADDR_W(ADDR_W)) i_pag_chk (
   .clk       (clk),
   .por_n     (por_n),
   .ctr_clr_n (ctr_clr_n),
   .ld_n      (ld_n),
   .inc_n     (inc_n),
   .ext_addr  (ext_addr),
   .acc_addr  (acc_addr)
);

// File: tb/test_port_addr_gen.sv
module test_port_addr_gen;

   localparam int AW = 14;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          ctr_clr_n = 1'b1;
   logic          ld_n = 1'b1;
   logic          inc_n = 1'b1;
   logic [AW-1:0] ext_addr = '0;
   logic          bank_sel_n = 1'b0;
   logic          bank_sel = 1'b1;
   logic [1:0]    lane_en_n = 2'b00;
   logic [AW-1:0] acc_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   port_addr_gen #(.ADDR_W(AW), .LANES(2)) i_port_addr_gen (
      .clk(clk), .por_n(por_n), .ctr_clr_n(ctr_clr_n), .ld_n(ld_n), .inc_n(inc_n),
      .ext_addr(ext_addr), .bank_sel_n(bank_sel_n), .bank_sel(bank_sel),
      .lane_en_n(lane_en_n), .acc_addr(acc_addr)
   );

   // {req, clr_n, ld_n, inc_n, ext_addr, expected}; starts from address 0
   localparam logic [34:0] VEC [NV] = '{
      {4'd3, 3'b101, 14'h1234, 14'h1234},
      {4'd4, 3'b110, 14'h0005, 14'h1235},
      {4'd4, 3'b110, 14'h0000, 14'h1236},
      {4'd5, 3'b111, 14'h3FFF, 14'h1236},
      {4'd2, 3'b000, 14'h2222, 14'h0000},
      {4'd8, 3'b110, 14'h0777, 14'h0001},
      {4'd3, 3'b100, 14'h3FFE, 14'h3FFE},
      {4'd4, 3'b110, 14'h0000, 14'h3FFF},
      {4'd6, 3'b110, 14'h0000, 14'h0000},
      {4'd2, 3'b010, 14'h0100, 14'h0000},
      {4'd3, 3'b101, 14'h0ABC, 14'h0ABC},
      {4'd5, 3'b111, 14'h0000, 14'h0ABC}
   };

   function automatic string rname(input int r);
      case (r)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input logic [AW-1:0] exp);
      checks++;
      if (acc_addr !== exp) begin
         errors++;
         $display("FAIL %s acc_addr=%h expected=%h at %0t", req, acc_addr, exp, $time);
      end
   endtask

   task automatic step(input logic c, input logic l, input logic i, input logic [AW-1:0] e);
      @(negedge clk);
      ctr_clr_n = c; ld_n = l; inc_n = i; ext_addr = e;
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   logic [AW-1:0] model;

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1", '0);            // reset state
      @(negedge clk);
      por_n = 1'b1;

      // vector table
      for (int k = 0; k < NV; k++) begin
         step(VEC[k][30], VEC[k][29], VEC[k][28], VEC[k][27:14]);
         check(rname(int'(VEC[k][34:31])), VEC[k][13:0]);
      end

      // R1: asynchronous power-on reset mid-run, sampled before any edge
      @(negedge clk);
      #1 por_n = 1'b0;
      #1 check("R1", '0);
      @(negedge clk);
      por_n = 1'b1;

      // R7: same sequence with the port deselected and lanes off
      bank_sel_n = 1'b1; bank_sel = 1'b0; lane_en_n = 2'b11;
      step(1'b1, 1'b0, 1'b1, 14'h0042); check("R7", 14'h0042);
      step(1'b1, 1'b1, 1'b0, 14'h0000); check("R7", 14'h0043);
      step(1'b1, 1'b1, 1'b1, 14'h1111); check("R7", 14'h0043);
      bank_sel_n = 1'b0; bank_sel = 1'b1; lane_en_n = 2'b01;
      step(1'b1, 1'b1, 1'b1, 14'h1111); check("R7", 14'h0043);
      step(1'b0, 1'b1, 1'b1, 14'h0000); check("R7", 14'h0000);

      // R8: clear then load at once
      step(1'b0, 1'b1, 1'b1, 14'h0000); check("R2", 14'h0000);
      step(1'b1, 1'b0, 1'b1, 14'h2A2A); check("R8", 14'h2A2A);

      // R6: wrap from the top after a load
      step(1'b1, 1'b0, 1'b0, 14'h3FFF); check("R3", 14'h3FFF);
      step(1'b1, 1'b1, 1'b0, 14'h0000); check("R6", 14'h0000);

      // random mixes against a reference model
      model = acc_addr;
      for (int n = 0; n < 400; n++) begin
         logic c, l, i;
         logic [AW-1:0] e;
         string tag;
         c = ($urandom_range(0, 9) != 0);
         l = ($urandom_range(0, 3) != 0);
         i = ($urandom_range(0, 2) == 0);
         e = AW'($urandom);
         bank_sel_n = 1'($urandom); bank_sel = 1'($urandom); lane_en_n = 2'($urandom);
         if (!c) begin model = '0; tag = "R2"; end
         else if (!l) begin model = e; tag = "R3"; end
         else if (!i) begin model = model + 1'b1; tag = "R4"; end
         else tag = "R5";
         step(c, l, i, e);
         check(tag, model);
      end

      finish_run();
   end

endmodule